// File: doc/BRIEF.md
# Stereo Serial Audio Receiver (Bit-Clock Slave)

This block receives a standard I2S stream. The bit clock and the word-select line both come from outside the block. A faster local system clock samples the bit clock, the word-select line and the single serial data line. Each input passes through a short synchroniser. The block then finds rising edges of the bit clock and captures one data bit on each edge. Both stereo channels share the one data line. Each value is a two's-complement word, sent most significant bit first.

Word boundaries come from transitions of the word-select line, not from a bit count. On the rising edge where a new word-select level first appears, the captured bit is still the last bit of the word that is ending. The next captured bit is the first bit of the new word. A word that ends while word select is low is a left sample. A word that ends while word select is high is a right sample. Once a right word completes after a held left word, both samples appear together on parallel outputs with a one-cycle strobe.

The configured sample width does not need to match the width the sender uses. Extra trailing bits are discarded. Missing low bits read as zero.

Top module: `stereo_serial_rx`

## Requirements
- R1: While `rst` is high and on the cycle after it, `pair_valid` is 0 and `left_out` and `right_out` are all zeros.
- R2: Data is taken only at rising edges of `bclk_in`. Changes of `sdata_in` or `lrsel_in` while `bclk_in` holds its level have no effect on the outputs.
- R3: The first bit of each word lands in bit SAMPLE_W-1 of the output. Each following bit lands one position lower.
- R4: A word sent while `lrsel_in` is 0 appears on `left_out`. A word sent while `lrsel_in` is 1 appears on `right_out`.
- R5: A word ends at the rising edge where `lrsel_in` is first seen at a new level. The bit captured at that edge is the last bit of the ending word. The bit captured at the next rising edge is the first bit of the new word.
- R6: If a word is longer than SAMPLE_W bits, only its first SAMPLE_W bits are kept.
- R7: If a word is shorter than SAMPLE_W bits, the output bits below the received ones are zero.
- R8: `left_out` and `right_out` change together, only in a cycle where `pair_valid` is 1. `pair_valid` is high for exactly one cycle, after the rising edge that completes a right word, and that edge sees `lrsel_in` low.
- R9: After reset, `pair_valid` stays low until a left word and then a right word have both been received whole. A word is whole only if it began just after a word-select transition. A right word with no whole left word before it produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above twice the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | External bit clock, asynchronous to `clk` |
| lrsel_in | input | 1 | External word select: 0 for left, 1 for right |
| sdata_in | input | 1 | Serial data, most significant bit first |
| left_out | output | SAMPLE_W | Left sample of the last completed pair |
| right_out | output | SAMPLE_W | Right sample of the last completed pair |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
On every cycle, the assertions check four things: the strobe lasts a single cycle and follows a detected bit-clock edge; the pair completes on an edge that sees word select low; the outputs hold still between strobes; and the bit counter never runs past the configured width. Some behaviour only the directed scenarios can show, because it depends on what the sender transmitted. That covers the sample values, the left/right placement, the bit order, truncation of long words, zero filling of short words, data glitches while the bit clock is high, and discarding the partial word cut at startup.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

  // Channel that a finished word belongs to, decided by the word-select level
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_in;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/ssrx_edge.sv
module ssrx_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_in;
  end

  assign rise = level_in & ~prev_q;

endmodule

// File: rtl/ssrx_shift.sv
module ssrx_shift #(
  parameter  int WORD_W = 16,
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_val,
  input  logic              restart,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  fill_cnt
);

  localparam logic [WORD_W-1:0] TOP_BIT = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]  FULL    = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] slot_mask;
  logic [CNT_W-1:0]  cnt_q;

  // Mask is empty once the word is full, so excess bits fall away
  assign slot_mask = TOP_BIT >> cnt_q;
  assign word_o    = bit_val ? (shreg_q | slot_mask) : shreg_q;
  assign fill_cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (bit_en) begin
      if (restart) begin
        shreg_q <= '0;
        cnt_q   <= '0;
      end else begin
        shreg_q <= word_o;
        if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ssrx_pair.sv
module ssrx_pair
  import ssrx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  chan_e             word_chan,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              pair_valid
);

  logic [WORD_W-1:0] left_hold_q;
  logic              have_left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_out    <= '0;
      right_out   <= '0;
      pair_valid  <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (word_done) begin
        if (word_chan == CH_LEFT) begin
          left_hold_q <= word_in;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_out    <= left_hold_q;
          right_out   <= word_in;
          pair_valid  <= 1'b1;
          have_left_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import ssrx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_in,
  input  logic                lrsel_in,
  input  logic                sdata_in,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                pair_valid
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic [2:0]          raw_in, sync_out;
  logic                bclk_s, ws_s, sd_s;
  logic                bit_rise;
  logic                ws_known_q, ws_last_q, in_word_q;
  logic                ws_edge, word_done;
  logic [SAMPLE_W-1:0] word_val;
  logic [CNT_W-1:0]    fill_cnt;

  assign raw_in = {bclk_in, lrsel_in, sdata_in};
  assign {bclk_s, ws_s, sd_s} = sync_out;

  ssrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw_in), .d_out(sync_out)
  );

  ssrx_edge u_edge (
    .clk(clk), .rst(rst), .level_in(bclk_s), .rise(bit_rise)
  );

  // Word-select tracking: the first edge after reset only learns the level
  assign ws_edge   = bit_rise & ws_known_q & (ws_s != ws_last_q);
  assign word_done = ws_edge & in_word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_known_q <= 1'b0;
      ws_last_q  <= 1'b0;
      in_word_q  <= 1'b0;
    end else if (bit_rise) begin
      ws_known_q <= 1'b1;
      ws_last_q  <= ws_s;
      if (ws_edge) in_word_q <= 1'b1;
    end
  end

  ssrx_shift #(.WORD_W(SAMPLE_W)) u_shift (
    .clk(clk), .rst(rst), .bit_en(bit_rise), .bit_val(sd_s),
    .restart(ws_edge), .word_o(word_val), .fill_cnt(fill_cnt)
  );

  ssrx_pair #(.WORD_W(SAMPLE_W)) u_pair (
    .clk(clk), .rst(rst), .word_done(word_done),
    .word_chan(chan_e'(ws_last_q)), .word_in(word_val),
    .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
  );

endmodule

// File: rtl/ssrx_checker.sv
module ssrx_checker #(
  parameter  int SAMPLE_W = 16,
  localparam int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                bit_rise,
  input logic                ws_s,
  input logic [CNT_W-1:0]    fill_cnt,
  input logic                pair_valid,
  input logic [SAMPLE_W-1:0] left_out,
  input logic [SAMPLE_W-1:0] right_out
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!pair_valid && left_out == '0 && right_out == '0));

  p_valid_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> $past(bit_rise));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(SAMPLE_W));

  p_pair_at_ws_low_r8: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> !$past(ws_s));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (rst)
    !pair_valid |-> ($stable(left_out) && $stable(right_out)));

endmodule

bind stereo_serial_rx ssrx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .bit_rise(bit_rise), .ws_s(ws_s),
  .fill_cnt(fill_cnt), .pair_valid(pair_valid),
  .left_out(left_out), .right_out(right_out)
);

// File: tb/stereo_serial_rx_tb.sv
module stereo_serial_rx_tb;

  localparam int W    = 16;
  localparam int HALF = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bclk = 1'b1;
  logic         lrsel = 1'b0;
  logic         sdata = 1'b0;
  logic [W-1:0] left_out, right_out;
  logic         pair_valid;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int double_pulse = 0;
  logic         prev_valid = 1'b0;
  logic [W-1:0] cap_l = '0, cap_r = '0;

  always #2 clk = ~clk;

  stereo_serial_rx #(.SAMPLE_W(W)) u_dut (
    .clk(clk), .rst(rst), .bclk_in(bclk), .lrsel_in(lrsel), .sdata_in(sdata),
    .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
  );

  always @(negedge clk) begin
    if (!rst && pair_valid) begin
      pulses = pulses + 1;
      cap_l  = left_out;
      cap_r  = right_out;
      if (prev_valid) double_pulse = double_pulse + 1;
    end
    prev_valid = pair_valid;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic ws, input logic b, input bit noise);
    @(negedge clk);
    bclk = 1'b0; lrsel = ws; sdata = b;
    repeat (HALF) @(negedge clk);
    bclk = 1'b1;
    repeat (HALF/2) @(negedge clk);
    if (noise) begin sdata = ~b; lrsel = ~ws; end
    repeat (HALF - HALF/2) @(negedge clk);
    if (noise) lrsel = ws;
  endtask

  // Last bit goes out with the next channel's word-select level
  task automatic send_word(input logic cur, input logic nxt, input logic [31:0] val,
                           input int n, input bit noise);
    for (int i = n - 1; i >= 0; i--) send_bit((i == 0) ? nxt : cur, val[i], noise);
  endtask

  task automatic frame_expect(input logic [31:0] l, input logic [31:0] r, input int n,
                              input bit noise, input logic [W-1:0] el,
                              input logic [W-1:0] er, input string req);
    int base;
    base = pulses;
    send_word(1'b0, 1'b1, l, n, noise);
    send_word(1'b1, 1'b0, r, n, noise);
    repeat (10) @(negedge clk);
    check(pulses == base + 1, {req, " pair count"}, 64'(pulses - base), 64'd1);
    check(cap_l == el, {req, " left"}, 64'(cap_l), 64'(el));
    check(cap_r == er, {req, " right"}, 64'(cap_r), 64'(er));
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pair_valid == 1'b0, "R1 valid after reset", 64'(pair_valid), 64'd0);
    check(left_out == '0 && right_out == '0, "R1 outputs after reset",
          64'({left_out, right_out}), 64'd0);
  endtask

  task automatic t_startup;
    int base;
    base = pulses;
    send_word(1'b0, 1'b1, 32'h15, 5, 1'b0);
    send_word(1'b1, 1'b0, 32'h5A5A, W, 1'b0);
    repeat (10) @(negedge clk);
    check(pulses == base, "R9 no pair without whole left word", 64'(pulses - base), 64'd0);
    frame_expect(32'h1234, 32'hBEEF, W, 1'b0, 16'h1234, 16'hBEEF, "R9 R5 first frame");
  endtask

  task automatic t_patterns;
    frame_expect(32'h8000, 32'h7FFF, W, 1'b0, 16'h8000, 16'h7FFF, "R3 sign and max");
    frame_expect(32'h0001, 32'hFFFE, W, 1'b0, 16'h0001, 16'hFFFE, "R4 channel placement");
    frame_expect(32'hC35A, 32'h0000, W, 1'b0, 16'hC35A, 16'h0000, "R5 boundary");
  endtask

  task automatic t_long;
    frame_expect(32'hABCDEF, 32'h123456, 24, 1'b0, 16'hABCD, 16'h1234, "R6 long words");
  endtask

  task automatic t_short;
    frame_expect(32'hABC, 32'h801, 12, 1'b0, 16'hABC0, 16'h8010, "R7 short words");
  endtask

  task automatic t_noise;
    frame_expect(32'h6C93, 32'h9E07, W, 1'b1, 16'h6C93, 16'h9E07, "R2 glitches while high");
  endtask

  task automatic t_hold;
    logic [W-1:0] l0, r0;
    int base;
    l0 = left_out; r0 = right_out; base = pulses;
    for (int k = 0; k < 20; k++) begin
      sdata = k[0]; lrsel = k[1];
      repeat (3) @(negedge clk);
    end
    lrsel = 1'b0;
    repeat (10) @(negedge clk);
    check(pulses == base, "R2 idle bit clock gives no pair", 64'(pulses - base), 64'd0);
    check(left_out == l0 && right_out == r0, "R8 outputs hold",
          64'({left_out, right_out}), 64'({l0, r0}));
    check(double_pulse == 0, "R8 single-cycle strobe", 64'(double_pulse), 64'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_startup();
        t_patterns();
        t_long();
        t_short();
        t_noise();
        t_hold();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule